// File: doc/BRIEF.md
# HDB3 Line Encoder

The encoder turns a serial NRZ bit stream into dual-rail pseudo-ternary HDB3 symbols. One output rail carries the positive marks and the other carries the negative marks. It takes one data bit on each rising edge of the transmit clock. Ones go out as marks of alternating polarity. When the data holds a run of four zeros, the encoder replaces part of that run with pulses, so that no more than three empty symbol slots ever follow one another on the line.

A short input delay line acts as a lookahead window. The encoder needs it because it must decide whether to substitute the first zero of a run before it has seen the last zero. Two polarity registers hold the history the substitution rule needs: the polarity of the last mark and the polarity of the last violation. Each output symbol is held in a rail register. That register is gated with the clock's high phase, so every pulse has return-to-zero form and lasts half a period. The delay line is cleared at reset, so the first four symbols after reset encode four zero bits.

Top module: `hdb3_line_enc`

## Requirements
- R1: A one bit is sent as a mark whose polarity is the opposite of the preceding mark, whether that mark was a data mark or a balancing mark.
- R2: When four zero bits in a row start a substitution group, the fourth slot carries a violation mark with the same polarity as the mark just before it.
- R3: At the first slot of a substitution group, a balancing mark of alternating polarity is sent if the last mark and the last violation have the same polarity; otherwise that slot stays empty.
- R4: Each violation has the polarity opposite to the previous violation.
- R5: The line never carries more than three empty symbol slots in a row.
- R6: The positive rail and the negative rail are never high together.
- R7: A rail goes high only while the clock is high, and both rails are low during every low phase of the clock.
- R8: A bit sampled on one rising edge reaches the rails after the fourth following rising edge (fixed latency of four cycles).
- R9: An active-low asynchronous reset forces both rails low at once. It clears the delay line to zeros and sets both polarity registers to negative. The first four symbols after reset are therefore positive, empty, empty, positive.
- R10: The running sum of line symbols, with a positive mark counted as +1 and a negative mark as -1, stays within -3 to +3 from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit clock; data sampled on the rising edge, pulses shaped by the high phase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nrz_i | input | 1 | Serial NRZ data bit |
| pos_o | output | 1 | Positive-mark rail, return-to-zero |
| neg_o | output | 1 | Negative-mark rail, return-to-zero |

## Verification
On every cycle the assertions check the registered rail state for four properties: the rails are never both high, the empty-slot run never exceeds three, each violation is opposite in polarity to the previous one, and a one bit seen five sampled edges earlier always produces a mark. Some requirements can only be shown by the bench's scenarios, because they depend on the data stream as a whole or on exact timing. These are the exact choice between a balancing mark and an empty first slot, which is compared against an independent whole-stream model over fixed patterns and a long zero-heavy pseudo-random stream. The same holds for the return-to-zero gating, for the asynchronous clearing of a rail that is high, and for the fixed positive/empty/empty/positive opening after reset.

// File: rtl/hdb3_pkg.sv
`timescale 1ns/1ps
package hdb3_pkg;
  typedef enum logic {POL_NEG = 1'b0, POL_POS = 1'b1} pol_e;
  typedef enum logic [1:0] {SYM_ZERO = 2'b00, SYM_POS = 2'b01, SYM_NEG = 2'b10} sym_e;

  function automatic sym_e mark_of(input pol_e p);
    return (p == POL_POS) ? SYM_POS : SYM_NEG;
  endfunction

  function automatic pol_e flip(input pol_e p);
    return (p == POL_POS) ? POL_NEG : POL_POS;
  endfunction
endpackage

// File: rtl/hdb3_delay_line.sv
`timescale 1ns/1ps
module hdb3_delay_line #(
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  output logic [DEPTH-1:0] tap_o
);
  logic [DEPTH-1:0] stage_q;

  // tap 0 is the newest bit, tap DEPTH-1 the next one to be coded
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
    logic in_bit;
    if (gi == 0) begin : g_head
      assign in_bit = d_i;
    end else begin : g_body
      assign in_bit = stage_q[gi-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[gi] <= 1'b0;
      else         stage_q[gi] <= in_bit;
    end
  end

  assign tap_o = stage_q;
endmodule

// File: rtl/hdb3_subst_ctrl.sv
`timescale 1ns/1ps
module hdb3_subst_ctrl
  import hdb3_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [WIN-1:0] win_i,
  output sym_e           sym_o
);
  localparam int CW = (WIN > 2) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] GRP_LEFT = CW'(WIN - 1);

  pol_e          last_mark_q, last_mark_d;
  pol_e          last_viol_q, last_viol_d;
  logic [CW-1:0] left_q, left_d;
  sym_e          sym_d;

  logic head_bit, run_zero;
  assign head_bit = win_i[WIN-1];
  assign run_zero = ~|win_i;

  always_comb begin
    last_mark_d = last_mark_q;
    last_viol_d = last_viol_q;
    left_d      = left_q;
    sym_d       = SYM_ZERO;
    if (left_q != '0) begin
      // inside a substitution group: trailing zeros, then the violation
      left_d = left_q - CW'(1);
      if (left_q == CW'(1)) begin
        sym_d       = mark_of(last_mark_q);
        last_viol_d = last_mark_q;
      end
    end else if (head_bit) begin
      sym_d       = mark_of(flip(last_mark_q));
      last_mark_d = flip(last_mark_q);
    end else if (run_zero) begin
      left_d = GRP_LEFT;
      if (last_mark_q == last_viol_q) begin
        sym_d       = mark_of(flip(last_mark_q));
        last_mark_d = flip(last_mark_q);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_mark_q <= POL_NEG;
      last_viol_q <= POL_NEG;
      left_q      <= '0;
    end else begin
      last_mark_q <= last_mark_d;
      last_viol_q <= last_viol_d;
      left_q      <= left_d;
    end
  end

  assign sym_o = sym_d;
endmodule

// File: rtl/hdb3_rz_out.sv
`timescale 1ns/1ps
module hdb3_rz_out
  import hdb3_pkg::*;
#(
  parameter bit RZ_GATE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  sym_e sym_i,
  output logic hold_pos_o,
  output logic hold_neg_o,
  output logic line_pos_o,
  output logic line_neg_o
);
  logic pos_q, neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else begin
      pos_q <= (sym_i == SYM_POS);
      neg_q <= (sym_i == SYM_NEG);
    end
  end

  if (RZ_GATE) begin : g_rz
    assign line_pos_o = pos_q & clk_i;
    assign line_neg_o = neg_q & clk_i;
  end else begin : g_full
    assign line_pos_o = pos_q;
    assign line_neg_o = neg_q;
  end

  assign hold_pos_o = pos_q;
  assign hold_neg_o = neg_q;
endmodule

// File: rtl/hdb3_line_enc.sv
`timescale 1ns/1ps
module hdb3_line_enc
  import hdb3_pkg::*;
#(
  parameter int MAX_ZEROS = 3,
  parameter bit RZ_GATE   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nrz_i,
  output logic pos_o,
  output logic neg_o
);
  localparam int WIN = MAX_ZEROS + 1;

  logic [WIN-1:0] win;
  sym_e           next_sym;
  logic           line_pos_q, line_neg_q;

  hdb3_delay_line #(.DEPTH(WIN)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (nrz_i),
    .tap_o (win)
  );

  hdb3_subst_ctrl #(.WIN(WIN)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .win_i (win),
    .sym_o (next_sym)
  );

  hdb3_rz_out #(.RZ_GATE(RZ_GATE)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sym_i     (next_sym),
    .hold_pos_o(line_pos_q),
    .hold_neg_o(line_neg_q),
    .line_pos_o(pos_o),
    .line_neg_o(neg_o)
  );
endmodule

// File: rtl/hdb3_line_enc_chk.sv
`timescale 1ns/1ps
module hdb3_line_enc_chk #(
  parameter int MAX_ZEROS = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic nrz_i,
  input logic pos_q,
  input logic neg_q
);
  localparam int ZW = $clog2(MAX_ZEROS + 2);
  localparam logic [ZW-1:0] ZSAT = ZW'(MAX_ZEROS + 1);

  logic [ZW-1:0] zrun_q;
  logic          prev_pos_q, viol_pos_q;
  logic [2:0]    warm_q;
  logic          mark_now, viol_now;

  assign mark_now = pos_q | neg_q;
  assign viol_now = mark_now && (pos_q == prev_pos_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zrun_q     <= '0;
      prev_pos_q <= 1'b0;
      viol_pos_q <= 1'b0;
      warm_q     <= '0;
    end else begin
      if (mark_now)            zrun_q <= '0;
      else if (zrun_q != ZSAT) zrun_q <= zrun_q + ZW'(1);
      if (mark_now) prev_pos_q <= pos_q;
      if (viol_now) viol_pos_q <= pos_q;
      if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
    end
  end

  a_r6_rails_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_q && neg_q));

  a_r5_zero_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zrun_q <= ZW'(MAX_ZEROS));

  a_r4_viol_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_now |-> (pos_q != viol_pos_q));

  a_r8_one_gives_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 3'd6 && $past(nrz_i, 5)) |-> mark_now);
endmodule

bind hdb3_line_enc hdb3_line_enc_chk #(.MAX_ZEROS(MAX_ZEROS)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .nrz_i (nrz_i),
  .pos_q (line_pos_q),
  .neg_q (line_neg_q)
);

// File: tb/sim_hdb3_line_enc.sv
`timescale 1ns/1ps
module sim_hdb3_line_enc;
  localparam int NPAT = 8;
  localparam int NRND = 1500;
  localparam int L    = NPAT * 16 + NRND;
  localparam logic [15:0] PAT [NPAT] = '{
    16'h0000, 16'hFFFF, 16'h8888, 16'h1111,
    16'hA0A0, 16'hF00F, 16'h0001, 16'h8421
  };

  logic clk_i = 1'b0;
  logic rst_ni, nrz_i, pos_o, neg_o;

  int    n_chk = 0, n_err = 0;
  bit    done  = 1'b0;
  logic  st   [0:L+3];
  int    sym  [0:L+3];
  string kind [0:L+3];

  always #2 clk_i = ~clk_i;

  hdb3_line_enc u0 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nrz_i (nrz_i),
    .pos_o (pos_o),
    .neg_o (neg_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int rails();
    if (pos_o && neg_o) return 2;
    if (pos_o) return 1;
    if (neg_o) return -1;
    return 0;
  endfunction

  initial begin
    logic [15:0] lf;
    int lm, lv, i, s, prev_mark, last_v, rds, pos_max;
    int open_seq [6];
    rst_ni = 1'b0;
    nrz_i  = 1'b0;

    // stream: four reset-filled zeros, the pattern table, then zero-heavy noise
    for (int k = 0; k < 4; k++) st[k] = 1'b0;
    for (int p = 0; p < NPAT; p++)
      for (int b = 0; b < 16; b++) st[4 + p*16 + b] = PAT[p][15-b];
    lf = 16'hACE1;
    for (int k = 0; k < NRND; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      st[4 + NPAT*16 + k] = lf[0] & lf[5];
    end

    // behavioural reference over the whole stream
    lm = -1; lv = -1; i = 0;
    while (i < L + 4) begin
      if (st[i]) begin
        lm = -lm; sym[i] = lm; kind[i] = "R1 R8 mark"; i++;
      end else if (i + 3 < L + 4 && !st[i+1] && !st[i+2] && !st[i+3]) begin
        if (lm == lv) begin lm = -lm; sym[i] = lm; kind[i] = "R3 balancing mark"; end
        else begin sym[i] = 0; kind[i] = "R3 empty first slot"; end
        sym[i+1] = 0; kind[i+1] = "R5 group zero";
        sym[i+2] = 0; kind[i+2] = "R5 group zero";
        sym[i+3] = lm; kind[i+3] = "R2 violation";
        lv = lm; i += 4;
      end else begin
        sym[i] = 0; kind[i] = "R5 zero"; i++;
      end
    end

    repeat (2) @(posedge clk_i);
    #1;
    chk("R9 rails low in reset", rails(), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    prev_mark = -1; last_v = -1; rds = 0; pos_max = 0;
    for (int k = 0; k < L; k++) begin
      nrz_i = st[k + 4];
      @(posedge clk_i);
      #1;
      s = rails();
      chk("R6 rails exclusive", (s == 2) ? 1 : 0, 0);
      chk(kind[k], s, sym[k]);
      if (s == 1 || s == -1) begin
        if (s == prev_mark) begin
          chk("R4 violation alternates", (s == last_v) ? 1 : 0, 0);
          last_v = s;
        end
        prev_mark = s;
        rds += s;
      end
      if (rds > pos_max) pos_max = rds;
      if (-rds > pos_max) pos_max = -rds;
      #2;
      chk("R7 rails low in low phase", (pos_o | neg_o) ? 1 : 0, 0);
    end
    chk("R10 running sum bounded", (pos_max <= 3) ? 1 : 0, 1);

    // async reset while a rail is high, then the fixed opening sequence
    nrz_i = 1'b1;
    repeat (8) @(posedge clk_i);
    #1;
    chk("R1 mark present before reset", (pos_o | neg_o) ? 1 : 0, 1);
    rst_ni = 1'b0;
    #0.5;
    chk("R9 async clear of high rail", (pos_o | neg_o) ? 1 : 0, 0);
    #1.5;
    rst_ni = 1'b1;
    open_seq = '{1, 0, 0, 1, -1, 1};
    for (int j = 0; j < 6; j++) begin
      nrz_i = 1'b1;
      @(posedge clk_i);
      #1;
      chk((j < 4) ? "R9 opening after reset" : "R8 first data after reset", rails(), open_seq[j]);
      #2;
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule